// File: doc/BRIEF.md
# Serial Security Key Host Controller

This block is the host side of a three-wire link to a small serial security key. It owns the three key-side wires: a transfer-enable (reset) line, a serial clock, and one data line that either end can drive. The data line is split into an output, an output enable and an input. A client hands over one request in a single cycle. The request holds the access type (read or write), a program flag, a 13-bit select code, a 64-bit identifier, a 64-bit match code and 128 bits of write data. The controller then raises the enable line, builds the 24-bit command word and clocks the whole transfer out bit by bit.

A normal transfer runs 280 serial cycles in four phases:
- the command word;
- 64 identifier bits read back from the key;
- 64 match-code bits written to the key;
- 128 data bits, read or written.

A program transfer runs 152 cycles: the command word, then 64 identifier bits and 64 match-code bits, all written. Read results appear on parallel outputs. A one-cycle done pulse marks the end of each transfer.

All serial timing comes from counters on the fast system clock. The clock low time, clock high time, enable-to-first-edge interval and enable recovery interval are parameters counted in system cycles. The serial clock rests high, and each serial cycle is a falling edge followed by a rising edge. The host changes its data only at a falling edge and samples key data on the last system cycle of each low phase.

Top module: `key_host`

## Requirements
- R1: After rst_ni is released, key_rst_o=0, key_clk_o=1, key_dq_oe_o=0, req_ready_o=1 and done_o=0.
- R2: Serial bit k of the command word is sent in serial cycle k, starting at k=0. The command word is built as follows:
  - Bits 0..7 carry the access code. Read sends 0,1,1,0,0,0,1,0 in that order. Write sends 1,0,0,1,1,1,0,1.
  - Bits 8 and 9 carry the mode: 1,0 for normal and 0,1 for program.
  - Bits 10..22 carry req_sel_i, least significant bit first.
  - Bit 23 is 1.
  - A program request always uses the write access code.
- R3: A normal transfer has exactly 280 rising key-clock edges while key_rst_o is high. A program transfer has exactly 152.
- R4: In normal mode, id_o bit j takes the key's data in serial cycle 24+j. After a normal read, rdata_o bit j takes the key's data in serial cycle 152+j. In both cases the host samples in the last system cycle of the low phase. Any output that a transfer does not read keeps its previous value.
- R5: key_dq_oe_o is high exactly in the host-driven cycles and low in the read cycles. The host-driven cycles are:
  - the command cycles;
  - cycles 88..151;
  - cycles 24..87 in program mode;
  - cycles 152..279 on a normal write.
  
  The written fields go out least significant bit first: in program mode req_id_i from cycle 24, req_match_i from cycle 88, and on a normal write req_wdata_i from cycle 152.
- R6: Every key-clock low phase lasts at least LOW_CYC system cycles. Every high phase between two low phases lasts at least HIGH_CYC.
- R7: key_rst_o is high for at least SETUP_CYC system cycles before the first falling key-clock edge of a transfer.
- R8: key_rst_o falls only while key_clk_o is high, and key_clk_o stays high whenever key_rst_o is low.
- R9: After key_rst_o falls, it stays low for at least RECOV_CYC system cycles before it rises again.
- R10: While the host drives the data line, key_dq_o changes only in the cycle in which key_clk_o falls.
- R11: done_o pulses once per transfer, for one cycle, in the cycle key_rst_o falls. req_ready_o is low whenever key_rst_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when req_ready_o is high |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_write_i | input | 1 | 1 = write the 128 data bits, 0 = read them |
| req_prog_i | input | 1 | 1 = program transfer |
| req_sel_i | input | 13 | Key select code |
| req_id_i | input | ID_W | Identifier to program |
| req_match_i | input | ID_W | Match code to send |
| req_wdata_i | input | MEM_W | Data to write |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| id_o | output | ID_W | Identifier read from the key |
| rdata_o | output | MEM_W | Data read from the key |
| key_rst_o | output | 1 | Transfer enable to the key |
| key_clk_o | output | 1 | Serial clock to the key |
| key_dq_o | output | 1 | Data driven toward the key |
| key_dq_oe_o | output | 1 | Host drives the data line |
| key_dq_i | input | 1 | Data line as seen by the host |

## Verification
The checker assumes that key_dq_i is synchronous to clk_i. It also assumes that the key changes the line only after a falling serial edge, and that requests arrive only while req_ready_o is high. The bench keeps to this with its key model, which updates its output on the falling edge of key_clk_o, and by holding each request until the controller reports idle. Field contents, select codes and key read data are random from a fixed seed. Directed cases add all-zero and all-one select codes, a program request that asks for read, and requests issued back to back.

// File: rtl/key_host_pkg.sv
`timescale 1ns/1ps
package key_host_pkg;
  localparam int SEL_W = 13;
  localparam int CMD_W = 8 + 2 + SEL_W + 1;
  // bit 0 of each constant is sent first
  localparam logic [7:0] OPC_RD    = 8'h46;
  localparam logic [7:0] OPC_WR    = 8'hB9;
  localparam logic [1:0] MODE_NORM = 2'b01;
  localparam logic [1:0] MODE_PROG = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH, ST_RECOV
  } st_e;
endpackage

// File: rtl/key_host_timer.sv
`timescale 1ns/1ps
module key_host_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/key_host_cmd.sv
`timescale 1ns/1ps
module key_host_cmd
  import key_host_pkg::*;
(
  input  logic             write_i,
  input  logic             prog_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CMD_W-1:0] word_o
);
  logic [7:0] opc;
  logic [1:0] mode;

  always_comb begin
    opc  = (write_i || prog_i) ? OPC_WR : OPC_RD;
    mode = prog_i ? MODE_PROG : MODE_NORM;
    word_o = {1'b1, sel_i, mode, opc};
  end
endmodule

// File: rtl/key_host_phase.sv
`timescale 1ns/1ps
module key_host_phase #(
  parameter int CMD_W = 24,
  parameter int ID_W  = 64,
  parameter int MEM_W = 128,
  parameter int IDX_W = 9
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             prog_i,
  input  logic             write_i,
  output logic             drive_o,
  output logic             cap_id_o,
  output logic             cap_data_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] B_ID    = IDX_W'(CMD_W);
  localparam logic [IDX_W-1:0] B_MATCH = IDX_W'(CMD_W + ID_W);
  localparam logic [IDX_W-1:0] B_DATA  = IDX_W'(CMD_W + 2*ID_W);
  localparam logic [IDX_W-1:0] L_PROG  = IDX_W'(CMD_W + 2*ID_W - 1);
  localparam logic [IDX_W-1:0] L_NORM  = IDX_W'(CMD_W + 2*ID_W + MEM_W - 1);

  logic in_cmd, in_id, in_match, in_data;

  always_comb begin
    in_cmd   = idx_i < B_ID;
    in_id    = (idx_i >= B_ID) && (idx_i < B_MATCH);
    in_match = (idx_i >= B_MATCH) && (idx_i < B_DATA);
    in_data  = idx_i >= B_DATA;
    drive_o    = in_cmd || in_match || (in_id && prog_i) ||
                 (in_data && write_i && !prog_i);
    cap_id_o   = in_id && !prog_i;
    cap_data_o = in_data && !prog_i && !write_i;
    last_o     = prog_i ? (idx_i == L_PROG) : (idx_i == L_NORM);
  end
endmodule

// File: rtl/key_host.sv
`timescale 1ns/1ps
module key_host
  import key_host_pkg::*;
#(
  parameter int LOW_CYC   = 26,
  parameter int HIGH_CYC  = 26,
  parameter int SETUP_CYC = 200,
  parameter int RECOV_CYC = 26,
  parameter int ID_W      = 64,
  parameter int MEM_W     = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic             req_prog_i,
  input  logic [SEL_W-1:0] req_sel_i,
  input  logic [ID_W-1:0]  req_id_i,
  input  logic [ID_W-1:0]  req_match_i,
  input  logic [MEM_W-1:0] req_wdata_i,
  output logic             done_o,
  output logic [ID_W-1:0]  id_o,
  output logic [MEM_W-1:0] rdata_o,
  output logic             key_rst_o,
  output logic             key_clk_o,
  output logic             key_dq_o,
  output logic             key_dq_oe_o,
  input  logic             key_dq_i
);
  localparam int NORM_BITS = CMD_W + 2*ID_W + MEM_W;
  localparam int IDX_W     = $clog2(NORM_BITS);
  localparam int MAX_AB    = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int MAX_CD    = (SETUP_CYC > RECOV_CYC) ? SETUP_CYC : RECOV_CYC;
  localparam int MAX_CYC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  st_e                  st_q;
  logic                 krst_q, kclk_q, done_q, prog_q, write_q;
  logic [NORM_BITS-1:0] tx_q;
  logic [IDX_W-1:0]     idx_q;
  logic [ID_W-1:0]      id_q;
  logic [MEM_W-1:0]     data_q;

  logic [CMD_W-1:0]     cmd_word;
  logic                 drive, cap_id, cap_data, last;
  logic                 tm_load, tm_exp;
  logic [CNT_W-1:0]     tm_val;

  key_host_cmd u_cmd (
    .write_i (req_write_i),
    .prog_i  (req_prog_i),
    .sel_i   (req_sel_i),
    .word_o  (cmd_word)
  );

  key_host_phase #(
    .CMD_W(CMD_W), .ID_W(ID_W), .MEM_W(MEM_W), .IDX_W(IDX_W)
  ) u_phase (
    .idx_i      (idx_q),
    .prog_i     (prog_q),
    .write_i    (write_q),
    .drive_o    (drive),
    .cap_id_o   (cap_id),
    .cap_data_o (cap_data),
    .last_o     (last)
  );

  key_host_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tm_load),
    .val_i    (tm_val),
    .expire_o (tm_exp)
  );

  // duration of the state being entered, minus one
  always_comb begin
    tm_load = 1'b0;
    tm_val  = '0;
    unique case (st_q)
      ST_IDLE: begin
        tm_load = req_valid_i;
        tm_val  = CNT_W'(SETUP_CYC - 1);
      end
      ST_SETUP: begin
        tm_load = tm_exp;
        tm_val  = CNT_W'(LOW_CYC - 1);
      end
      ST_LOW: begin
        tm_load = tm_exp;
        tm_val  = CNT_W'(HIGH_CYC - 1);
      end
      ST_HIGH: begin
        tm_load = tm_exp;
        tm_val  = last ? CNT_W'(RECOV_CYC - 1) : CNT_W'(LOW_CYC - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      krst_q  <= 1'b0;
      kclk_q  <= 1'b1;
      done_q  <= 1'b0;
      prog_q  <= 1'b0;
      write_q <= 1'b0;
      tx_q    <= '0;
      idx_q   <= '0;
      id_q    <= '0;
      data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          tx_q    <= {req_wdata_i, req_match_i,
                      req_prog_i ? req_id_i : '0, cmd_word};
          prog_q  <= req_prog_i;
          write_q <= req_write_i || req_prog_i;
          idx_q   <= '0;
          krst_q  <= 1'b1;
          st_q    <= ST_SETUP;
        end
        ST_SETUP: if (tm_exp) begin
          kclk_q <= 1'b0;
          st_q   <= ST_LOW;
        end
        ST_LOW: if (tm_exp) begin
          if (cap_id)   id_q   <= {key_dq_i, id_q[ID_W-1:1]};
          if (cap_data) data_q <= {key_dq_i, data_q[MEM_W-1:1]};
          kclk_q <= 1'b1;
          st_q   <= ST_HIGH;
        end
        ST_HIGH: if (tm_exp) begin
          if (last) begin
            krst_q <= 1'b0;
            done_q <= 1'b1;
            st_q   <= ST_RECOV;
          end else begin
            idx_q  <= idx_q + 1'b1;
            tx_q   <= tx_q >> 1;
            kclk_q <= 1'b0;
            st_q   <= ST_LOW;
          end
        end
        ST_RECOV: if (tm_exp) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign done_o      = done_q;
  assign id_o        = id_q;
  assign rdata_o     = data_q;
  assign key_rst_o   = krst_q;
  assign key_clk_o   = kclk_q;
  assign key_dq_o    = tx_q[0];
  assign key_dq_oe_o = krst_q && drive;
endmodule

// File: rtl/key_host_chk.sv
`timescale 1ns/1ps
module key_host_chk #(
  parameter int LOW_CYC   = 26,
  parameter int HIGH_CYC  = 26,
  parameter int SETUP_CYC = 200,
  parameter int RECOV_CYC = 26
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic done_o,
  input logic key_rst_o,
  input logic key_clk_o,
  input logic key_dq_o,
  input logic key_dq_oe_o
);
  logic [31:0] lo_cnt, hi_cnt, rhi_cnt, rlo_cnt;
  logic        fell_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt    <= '0;
      hi_cnt    <= '0;
      rhi_cnt   <= '0;
      rlo_cnt   <= 32'(RECOV_CYC);
      fell_seen <= 1'b0;
    end else begin
      lo_cnt  <= key_clk_o ? '0 : lo_cnt + 1;
      hi_cnt  <= key_clk_o ? hi_cnt + 1 : '0;
      rhi_cnt <= key_rst_o ? rhi_cnt + 1 : '0;
      rlo_cnt <= key_rst_o ? '0 : rlo_cnt + 1;
      if (!key_rst_o)      fell_seen <= 1'b0;
      else if (!key_clk_o) fell_seen <= 1'b1;
    end
  end

  a_r6_low_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_clk_o && lo_cnt != 0) |-> lo_cnt >= 32'(LOW_CYC));
  a_r6_high_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!key_clk_o && hi_cnt != 0) |-> hi_cnt >= 32'(HIGH_CYC));
  a_r7_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_rst_o && !key_clk_o && !fell_seen) |-> rhi_cnt >= 32'(SETUP_CYC));
  a_r8_clk_high_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_rst_o |-> key_clk_o);
  a_r9_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(key_rst_o) |-> rlo_cnt >= 32'(RECOV_CYC));
  a_r10_data_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_dq_oe_o && $past(key_dq_oe_o) && !$stable(key_dq_o)) |-> $fell(key_clk_o));
  a_r5_no_drive_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_rst_o |-> !key_dq_oe_o);
  a_r11_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(key_rst_o));
  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_rst_o |-> !req_ready_o);
endmodule

bind key_host key_host_chk #(
  .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC),
  .SETUP_CYC(SETUP_CYC), .RECOV_CYC(RECOV_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .key_rst_o   (key_rst_o),
  .key_clk_o   (key_clk_o),
  .key_dq_o    (key_dq_o),
  .key_dq_oe_o (key_dq_oe_o)
);

// File: tb/tb_key_host.sv
`timescale 1ns/1ps
module tb_key_host;
  localparam int LOWC = 4, HIGHC = 4, SETUPC = 8, RECOVC = 3;
  localparam int NB = 280;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_write_i = 1'b0, req_prog_i = 1'b0;
  logic [12:0]  req_sel_i = '0;
  logic [63:0]  req_id_i = '0, req_match_i = '0;
  logic [127:0] req_wdata_i = '0;
  logic req_ready_o, done_o, key_rst_o, key_clk_o, key_dq_o, key_dq_oe_o, key_dq_i;
  logic [63:0]  id_o;
  logic [127:0] rdata_o;

  always #2.5 clk_i = ~clk_i;

  key_host #(.LOW_CYC(LOWC), .HIGH_CYC(HIGHC), .SETUP_CYC(SETUPC),
             .RECOV_CYC(RECOVC)) dut (.*);

  int n_chk = 0, n_fail = 0;

  // key model
  logic [NB-1:0] rd_vec = '0, cap_bits = '0, cap_oe = '0;
  int  rise_cnt = 0, last_bits = 0;
  logic key_drv = 1'b0;

  always @(posedge key_clk_o or negedge key_rst_o) begin
    if (!key_rst_o) begin
      if (rise_cnt != 0) last_bits <= rise_cnt;
      rise_cnt <= 0;
    end else begin
      if (rise_cnt < NB) begin
        cap_bits[rise_cnt] <= key_dq_o;
        cap_oe[rise_cnt]   <= key_dq_oe_o;
      end
      rise_cnt <= rise_cnt + 1;
    end
  end

  always @(negedge key_clk_o) key_drv <= (rise_cnt < NB) ? rd_vec[rise_cnt] : 1'b0;

  assign key_dq_i = key_dq_oe_o ? key_dq_o : key_drv;

  // timing monitor, sampled away from the active edge
  int lo_run = 0, hi_run = 0, rst_run = 0, rec_run = 1000;
  int min_lo = 1000000, min_hi = 1000000, setup_seen = 0, rec_seen = 1000, done_cnt = 0;
  bit first_fall = 1'b0, bad_fall = 1'b0, bad_ready = 1'b0, bad_chg = 1'b0;
  logic pk = 1'b1, pr = 1'b0, poe = 1'b0, pdq = 1'b0;

  always @(negedge clk_i) if (rst_ni) begin
    if (key_rst_o && !pr) begin
      rec_seen = rec_run; rec_run = 0; rst_run = 0; first_fall = 1'b0;
      min_lo = 1000000; min_hi = 1000000;
    end
    if (!key_rst_o && !key_clk_o) bad_fall = 1'b1;
    if (key_rst_o && req_ready_o) bad_ready = 1'b1;
    if (done_o) done_cnt++;
    if (key_dq_oe_o && poe && key_dq_o != pdq && !(pk && !key_clk_o)) bad_chg = 1'b1;
    if (key_rst_o && !key_clk_o && pk) begin
      if (!first_fall) begin setup_seen = rst_run; first_fall = 1'b1; end
      else if (hi_run < min_hi) min_hi = hi_run;
    end
    if (key_rst_o && key_clk_o && !pk && lo_run < min_lo) min_lo = lo_run;
    if (key_clk_o) begin hi_run++; lo_run = 0; end else begin lo_run++; hi_run = 0; end
    if (key_rst_o) rst_run++; else rec_run++;
    pk = key_clk_o; pr = key_rst_o; poe = key_dq_oe_o; pdq = key_dq_o;
  end

  task automatic check(input bit ok, input string tag,
                       input logic [NB-1:0] act, input logic [NB-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_cmd(bit wr, bit pg, logic [12:0] sel);
    logic [23:0] c;
    logic [7:0]  seq;
    seq = (wr || pg) ? 8'b10011101 : 8'b01100010; // leftmost goes first
    for (int i = 0; i < 8; i++) c[i] = seq[7-i];
    c[8]     = pg ? 1'b0 : 1'b1;
    c[9]     = pg ? 1'b1 : 1'b0;
    c[22:10] = sel;
    c[23]    = 1'b1;
    return c;
  endfunction

  logic [63:0]  prev_id = '0;
  logic [127:0] prev_data = '0;

  task automatic run_txn(input bit wr, input bit pg, input logic [12:0] sel,
                         input logic [63:0] idv, input logic [63:0] mv,
                         input logic [127:0] wd);
    int nb, d0, wait_cyc;
    logic [NB-1:0] e_oe, e_tx, m;
    logic [23:0] ec;
    for (int k = 0; k < NB; k++) rd_vec[k] = 1'($urandom_range(0, 1));
    while (!req_ready_o) @(negedge clk_i);
    req_write_i = wr; req_prog_i = pg; req_sel_i = sel;
    req_id_i = idv; req_match_i = mv; req_wdata_i = wd;
    d0 = done_cnt;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    wait_cyc = 0;
    while (done_cnt == d0 && wait_cyc < 6000) begin @(negedge clk_i); wait_cyc++; end
    check(wait_cyc < 6000, "R11 done timeout", NB'(wait_cyc), NB'(6000));
    repeat (2) @(negedge clk_i);
    nb = pg ? 152 : 280;
    ec = exp_cmd(wr, pg, sel);
    e_oe = '0; e_tx = '0; m = '0;
    for (int k = 0; k < nb; k++) begin
      m[k] = 1'b1;
      if (k < 24) begin e_oe[k] = 1'b1; e_tx[k] = ec[k]; end
      else if (k < 88) begin if (pg) begin e_oe[k] = 1'b1; e_tx[k] = idv[k-24]; end end
      else if (k < 152) begin e_oe[k] = 1'b1; e_tx[k] = mv[k-88]; end
      else if (wr) begin e_oe[k] = 1'b1; e_tx[k] = wd[k-152]; end
    end
    check(last_bits == nb, "R3 edge count", NB'(last_bits), NB'(nb));
    check(cap_bits[23:0] == ec, "R2 command word", NB'(cap_bits[23:0]), NB'(ec));
    check((cap_oe & m) == e_oe, "R5 drive direction", cap_oe & m, e_oe);
    check((cap_bits & e_oe) == e_tx, "R5 written bits", cap_bits & e_oe, e_tx);
    if (!pg) begin
      check(id_o == rd_vec[87:24], "R4 identifier", NB'(id_o), NB'(rd_vec[87:24]));
      prev_id = rd_vec[87:24];
    end else
      check(id_o == prev_id, "R4 id held", NB'(id_o), NB'(prev_id));
    if (!pg && !wr) begin
      check(rdata_o == rd_vec[279:152], "R4 read data", NB'(rdata_o), NB'(rd_vec[279:152]));
      prev_data = rd_vec[279:152];
    end else
      check(rdata_o == prev_data, "R4 data held", NB'(rdata_o), NB'(prev_data));
    check(min_lo >= LOWC, "R6 low time", NB'(min_lo), NB'(LOWC));
    check(min_hi >= HIGHC, "R6 high time", NB'(min_hi), NB'(HIGHC));
    check(setup_seen >= SETUPC, "R7 setup", NB'(setup_seen), NB'(SETUPC));
    check(!bad_fall, "R8 enable falls with clock high", NB'(bad_fall), NB'(0));
    check(rec_seen >= RECOVC, "R9 recovery", NB'(rec_seen), NB'(RECOVC));
    check(!bad_chg, "R10 data changes at fall only", NB'(bad_chg), NB'(0));
    check(done_cnt == d0 + 1, "R11 one done pulse", NB'(done_cnt - d0), NB'(1));
    check(!bad_ready, "R11 ready low while busy", NB'(bad_ready), NB'(0));
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check({key_rst_o, key_clk_o, key_dq_oe_o, req_ready_o, done_o} == 5'b01010,
          "R1 reset state",
          NB'({key_rst_o, key_clk_o, key_dq_oe_o, req_ready_o, done_o}), NB'(5'b01010));
    run_txn(1'b0, 1'b0, 13'h0000, '0, 64'h0123_4567_89AB_CDEF, '0);
    run_txn(1'b1, 1'b0, 13'h1FFF, '0, 64'hFFFF_0000_AAAA_5555,
            128'hDEAD_BEEF_0000_FFFF_1234_5678_9ABC_DEF0);
    run_txn(1'b0, 1'b1, 13'h0A5A, 64'hFEDC_BA98_7654_3210, 64'h1, '0); // program forces write
    run_txn(1'b1, 1'b1, 13'h1555, '1, '0, '1);
    for (int t = 0; t < 10; t++)
      run_txn(1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
              13'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
              {$urandom, $urandom, $urandom, $urandom});
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
    $finish;
  end
endmodule